// File: doc/BRIEF.md
# Jacobian Logarithm Unit with Power-Gated Correction Lookup

This unit evaluates max*(a,b) = ln(e^a + e^b) on two fixed-point path metrics of a soft-output trellis decoder. It splits the function into the larger input plus a small correction ln(1 + e^-d), where d is the magnitude of the difference of the inputs. It takes that correction from a compact on-chip lookup memory indexed by d.

Once d is past 5.0 the correction is below half of one least significant bit. A threshold detector on the difference then keeps the lookup memory idle for that operand pair, and the output selector adds zero instead of the table word. The unit takes one operand pair per cycle when `inValid` is high. It returns the sum two cycles later with `outValid`, whether the table was read or not. `tableEn` exposes the memory read enable so that the saved reads can be observed.

Metrics are signed with 3 fractional bits (one LSB = 1/8). The table covers difference codes 0 to 40, that is d from 0.0 to 5.0 inclusive. Each entry is round(8 * ln(1 + e^-(code/8))). Trellis scheduling and the decoder datapath around the unit are not part of this block.

Top module: `maxstar_unit`

## Requirements
- R1: For |a-b| of at most 40 codes, `result` equals max(a,b) + round(8*ln(1+e^-(|a-b|/8))), where all values are signed integers in 1/8 units. The correction therefore lies between 0 and 6.
- R2: For |a-b| greater than 40 codes, `result` equals max(a,b) exactly. This holds even when the previous operation read a nonzero correction.
- R3: `tableEn` is high only in a cycle where `inValid` is high and |a-b| is at most 40 codes. The number of cycles with `tableEn` high equals the number of such accepted operand pairs.
- R4: A difference of exactly 40 codes (5.0) still reads the table and adds a correction of 0. A difference of 41 codes does not read the table.
- R5: `outValid` goes high exactly two clock cycles after each cycle with `inValid` high, and only then. One operand pair can be accepted in every cycle, back to back.
- R6: While `rstN` is low, and in the first cycle after it is released, `outValid` is 0, `result` is 0 and `tableEn` is 0 when `inValid` is 0.
- R7: The result does not depend on operand order: max*(a,b) equals max*(b,a).
- R8: `result` is 13 bits wide and signed, so full-scale inputs (2047, -2048) give max + correction without wrap-around.
- R9: `result` keeps its last value in every cycle in which `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand pair present this cycle |
| metricA | input | 12 | First metric, signed, 3 fractional bits |
| metricB | input | 12 | Second metric, signed, 3 fractional bits |
| outValid | output | 1 | `result` holds a new value |
| result | output | 13 | max*(metricA, metricB), signed, 3 fractional bits |
| tableEn | output | 1 | Read enable of the correction lookup memory |

## Verification
A new near-difference pair can launch a table read in the same cycle that the output selector is handling the previous pair. When that previous pair was a far pair, the selector must discard the stale word still in the table register. The bench provokes this with back-to-back streams that alternate near and far pairs, including the 40/41 code edge and pairs with equal inputs, which give the largest correction. A scoreboard checks every result against a correction computed in real arithmetic in the bench. A per-cycle count of `tableEn` is compared with the number of near pairs that were sent.

// File: rtl/maxstar_pkg.sv
package maxstar_pkg;

  // Strobes handed from the control path to the datapath each cycle.
  typedef struct packed {
    logic capture;   // latch the larger operand into stage 1
    logic tblRead;   // read the correction memory this cycle
    logic useCorr;   // stage-1 operand owns a valid table word
    logic outLoad;   // update the output register
  } ctrlStrobes_t;

  // Number of table entries for a given format and threshold.
  function automatic int tableDepth(input int fracW, input int thrInt);
    return (thrInt << fracW) + 1;
  endfunction

endpackage

// File: rtl/maxstar_corr_rom.sv
module maxstar_corr_rom #(
  parameter int FRAC_W = 3,
  parameter int DEPTH  = 41,
  parameter int ADDR_W = 6,
  parameter int CORR_W = 3
) (
  input  logic              clk,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output logic [CORR_W-1:0] data
);

  // round(8 * ln(1 + exp(-k/8))) for k = 0 .. DEPTH-1
  function automatic logic [CORR_W-1:0] corrOf(input logic [ADDR_W-1:0] k);
    int idx;
    idx = int'(k);
    if (idx == 0)            return CORR_W'(6);
    else if (idx <= 2)       return CORR_W'(5);
    else if (idx <= 4)       return CORR_W'(4);
    else if (idx <= 8)       return CORR_W'(3);
    else if (idx <= 12)      return CORR_W'(2);
    else if (idx <= 21)      return CORR_W'(1);
    else                     return CORR_W'(0);
  endfunction

  generate
    if (FRAC_W != 3) begin : g_fmtCheck
      $error("maxstar_corr_rom: entries are laid out for 3 fractional bits");
    end
    if (DEPTH > (1 << ADDR_W)) begin : g_depthCheck
      $error("maxstar_corr_rom: address too narrow for depth");
    end
  endgenerate

  // Registered synchronous read; the word holds while rdEn is low.
  always_ff @(posedge clk) begin
    if (rdEn) begin
      data <= corrOf(addr);
    end
  end

endmodule

// File: rtl/maxstar_ctrl.sv
module maxstar_ctrl
  import maxstar_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         farDiff,
  output ctrlStrobes_t strobes,
  output logic         outValid
);

  logic validS1;
  logic readS1;
  logic tblReadNow;

  // The pre-decode gate: skip the memory when the difference is far.
  assign tblReadNow = inValid & ~farDiff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validS1  <= 1'b0;
      readS1   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      validS1  <= inValid;
      readS1   <= tblReadNow;
      outValid <= validS1;
    end
  end

  always_comb begin
    strobes.capture = inValid;
    strobes.tblRead = tblReadNow;
    strobes.useCorr = readS1;
    strobes.outLoad = validS1;
  end

endmodule

// File: rtl/maxstar_dp.sv
module maxstar_dp
  import maxstar_pkg::*;
#(
  parameter int IN_W   = 12,
  parameter int DEPTH  = 41,
  parameter int ADDR_W = 6,
  parameter int CORR_W = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [IN_W-1:0]  metricA,
  input  logic signed [IN_W-1:0]  metricB,
  input  ctrlStrobes_t            strobes,
  input  logic [CORR_W-1:0]       corrWord,
  output logic                    farDiff,
  output logic [ADDR_W-1:0]       tblAddr,
  output logic signed [IN_W:0]    result
);

  localparam int MAG_W = IN_W + 1;
  localparam int OUT_W = IN_W + 1;
  localparam logic [MAG_W-1:0] LAST_IDX = MAG_W'(DEPTH - 1);

  logic signed [MAG_W-1:0] diffFull;
  logic                    aNotLess;
  logic        [MAG_W-1:0] diffMag;
  logic signed [IN_W-1:0]  maxNow;
  logic signed [IN_W-1:0]  maxS1;
  logic        [CORR_W-1:0] corrSel;
  logic signed [OUT_W-1:0] sumNext;

  // Stage 0: widened subtraction, magnitude, larger operand.
  always_comb begin
    diffFull = {metricA[IN_W-1], metricA} - {metricB[IN_W-1], metricB};
    aNotLess = ~diffFull[MAG_W-1];
    diffMag  = aNotLess ? diffFull : -diffFull;
    maxNow   = aNotLess ? metricA : metricB;
    farDiff  = diffMag > LAST_IDX;
    tblAddr  = diffMag[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maxS1 <= '0;
    end else if (strobes.capture) begin
      maxS1 <= maxNow;
    end
  end

  // Stage 1: selector chooses the table word or zero, then the add.
  always_comb begin
    corrSel = strobes.useCorr ? corrWord : '0;
    sumNext = {maxS1[IN_W-1], maxS1} + {{(OUT_W-CORR_W){1'b0}}, corrSel};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
    end else if (strobes.outLoad) begin
      result <= sumNext;
    end
  end

endmodule

// File: rtl/maxstar_unit.sv
module maxstar_unit
  import maxstar_pkg::*;
#(
  parameter int IN_W   = 12,
  parameter int FRAC_W = 3,
  parameter int THR_INT = 5,
  parameter int CORR_W = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic signed [IN_W-1:0] metricA,
  input  logic signed [IN_W-1:0] metricB,
  output logic                   outValid,
  output logic signed [IN_W:0]   result,
  output logic                   tableEn
);

  localparam int DEPTH  = tableDepth(FRAC_W, THR_INT);
  localparam int ADDR_W = $clog2(DEPTH);

  ctrlStrobes_t      strobes;
  logic              farDiff;
  logic [ADDR_W-1:0] tblAddr;
  logic [CORR_W-1:0] corrWord;

  maxstar_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .farDiff  (farDiff),
    .strobes  (strobes),
    .outValid (outValid)
  );

  maxstar_dp #(
    .IN_W   (IN_W),
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .CORR_W (CORR_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .metricA  (metricA),
    .metricB  (metricB),
    .strobes  (strobes),
    .corrWord (corrWord),
    .farDiff  (farDiff),
    .tblAddr  (tblAddr),
    .result   (result)
  );

  maxstar_corr_rom #(
    .FRAC_W (FRAC_W),
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .CORR_W (CORR_W)
  ) i_rom (
    .clk  (clk),
    .rdEn (strobes.tblRead),
    .addr (tblAddr),
    .data (corrWord)
  );

  assign tableEn = strobes.tblRead;

endmodule

// File: rtl/maxstar_unit_chk.sv
module maxstar_unit_chk #(
  parameter int IN_W   = 12,
  parameter int FRAC_W = 3,
  parameter int THR_INT = 5,
  parameter int CORR_W = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   inValid,
  input logic signed [IN_W-1:0] metricA,
  input logic signed [IN_W-1:0] metricB,
  input logic                   outValid,
  input logic signed [IN_W:0]   result,
  input logic                   tableEn
);

  localparam int LAST = (THR_INT << FRAC_W);

  logic signed [IN_W:0] wideA;
  logic signed [IN_W:0] wideB;
  logic signed [IN_W:0] maxAB;
  int                   gap;

  always_comb begin
    wideA = {metricA[IN_W-1], metricA};
    wideB = {metricB[IN_W-1], metricB};
    maxAB = (wideA > wideB) ? wideA : wideB;
    gap   = (wideA > wideB) ? int'(wideA) - int'(wideB) : int'(wideB) - int'(wideA);
  end

  AST_EN_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    tableEn |-> inValid);                                                   // R3
  AST_EN_NEAR: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && gap <= LAST) |-> tableEn);                                  // R4
  AST_LAT_ON: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##1 outValid);                                              // R5
  AST_LAT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ##1 !outValid);                                            // R5
  AST_FAR_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && gap > LAST) |=> ##1 (result == $past(maxAB, 2)));           // R2
  AST_CORR_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##1 ((result >= $past(maxAB, 2)) && (result <= $past(maxAB, 2) + 6))); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(result));                                         // R9

endmodule

bind maxstar_unit maxstar_unit_chk #(
  .IN_W    (IN_W),
  .FRAC_W  (FRAC_W),
  .THR_INT (THR_INT),
  .CORR_W  (CORR_W)
) i_chk (.*);

// File: tb/test_maxstar_unit.sv
`timescale 1ns/1ps
module test_maxstar_unit;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic signed [11:0] metricA = '0;
  logic signed [11:0] metricB = '0;
  logic              outValid;
  logic signed [12:0] result;
  logic              tableEn;

  int testsRun = 0;
  int testsFailed = 0;
  int expReads = 0;
  int seenReads = 0;
  bit monitorOn = 1'b0;
  bit haveLast = 1'b0;
  logic signed [12:0] lastResult = '0;

  typedef struct {
    int    value;
    string tag;
  } expItem_t;
  expItem_t scoreQ[$];

  always #2.5 clk = ~clk;

  maxstar_unit i_maxstar_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .metricA(metricA), .metricB(metricB),
    .outValid(outValid), .result(result), .tableEn(tableEn)
  );

  function automatic int refCorr(input int gap);
    real x;
    if (gap > 40) return 0;
    x = $ln(1.0 + $exp(-(real'(gap) / 8.0))) * 8.0;
    return $rtoi(x + 0.5);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int a, input int b, input string tag);
    int gap;
    int mx;
    bit near;
    expItem_t it;
    @(negedge clk);
    inValid = 1'b1;
    metricA = 12'(a);
    metricB = 12'(b);
    gap = (a > b) ? a - b : b - a;
    mx = (a > b) ? a : b;
    near = (gap <= 40);
    if (near) expReads++;
    it.value = mx + refCorr(gap);
    it.tag = tag;
    scoreQ.push_back(it);
    #1;
    check(tableEn == near, "R3 tableEn per pair", int'(tableEn), int'(near));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      metricA = 12'(i * 37);
      metricB = -12'(i * 53);
      #1;
      check(tableEn == 1'b0, "R3 no read when idle", int'(tableEn), 0);
    end
  endtask

  always @(posedge clk) begin
    if (rstN && tableEn) seenReads++;
  end

  // Monitor: compares each produced result with the head of the queue.
  always @(negedge clk) begin
    if (monitorOn) begin
      if (outValid) begin
        if (scoreQ.size() == 0) begin
          check(1'b0, "R5 unexpected outValid", 1, 0);
        end else begin
          expItem_t it;
          it = scoreQ.pop_front();
          check(int'(result) == it.value, it.tag, int'(result), it.value);
        end
        lastResult = result;
        haveLast = 1'b1;
      end else if (haveLast) begin
        check(result == lastResult, "R9 hold while idle", int'(result), int'(lastResult));
      end
    end
  end

  initial begin
    #400000;
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R6 outValid in reset", int'(outValid), 0);
    check(result == 13'sd0, "R6 result in reset", int'(result), 0);
    check(tableEn == 1'b0, "R6 tableEn in reset", int'(tableEn), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R6 outValid after release", int'(outValid), 0);
    check(result == 13'sd0, "R6 result after release", int'(result), 0);
    monitorOn = 1'b1;

    // R1: equal inputs give the largest correction
    drive(100, 100, "R1 equal inputs");
    idle(3);
    // R1/R2: sweep of differences, back to back, both signs
    for (int d = 0; d <= 48; d++) drive(-200, -200 + d, "R1 R2 sweep b larger");
    for (int d = 0; d <= 48; d++) drive(300 + d, 300, "R1 R2 sweep a larger");
    idle(2);
    // R4: edge of the threshold
    drive(0, 40, "R4 gap 40 reads, corr 0");
    drive(0, 41, "R4 gap 41 skipped");
    drive(-40, 0, "R4 gap 40 negative side");
    drive(-41, 0, "R4 gap 41 negative side");
    // R2: far pair right after a near pair with a nonzero stale word
    drive(5, 5, "R2 near before far");
    drive(5, 500, "R2 far after near, stale ignored");
    drive(-7, -8, "R2 near again");
    drive(-900, -7, "R2 far after near again");
    idle(1);
    // R7: operand order
    drive(17, 26, "R7 order ab");
    drive(26, 17, "R7 order ba");
    drive(-3, 2, "R7 order ab neg");
    drive(2, -3, "R7 order ba neg");
    // R8: full-scale operands
    drive(2047, 2047, "R8 top equal");
    drive(2047, -2048, "R8 full span");
    drive(-2048, -2048, "R8 bottom equal");
    drive(2040, 2047, "R8 near top");
    idle(5);
    monitorOn = 1'b0;
    check(scoreQ.size() == 0, "R5 all results returned", scoreQ.size(), 0);
    check(seenReads == expReads, "R3 table read count", seenReads, expReads);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule